// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This unit sits beside the command engine of a serial nonvolatile memory and decides, request by request, whether a write, erase or status-register write may go ahead. It holds the status register: the write-enable latch, two block-protect bits that select how much of the top of the address space is locked, and a protect-pin enable bit that lets an external active-low lock pin freeze the status register. The nonvolatile bits are modelled as ordinary flip-flops that take a parameterised value at reset.

The command engine presents each decoded request on a valid/ready port as a kind code, a target address and a data byte. The unit holds `req_ready` low while the array reports busy. While `req_valid` is high and `req_ready` is low, the engine must keep the request fields stable. There is no back-pressure on the result: exactly one cycle after a request is accepted, `resp_valid` pulses with `resp_grant` set or clear. The status byte is always readable at `status_o`, and the current nonvolatile bits are available at `nv_o` for storage.

Top module: `wpg_status_guard`

## Requirements
- R1: `status_o` is {pe, 0, 0, 0, bp[1], bp[0], wel, busy_i}, with bits 6:4 always 0 and bit 0 following `busy_i` in the same cycle. `nv_o` is {pe, bp[1:0]}. Reset clears wel, and with the default parameters it also clears pe and bp, so the status byte reads 00h.
- R2: Request kind codes are: 0 set-enable, 1 clear-enable, 2 status write, 3 data write, 4 page erase, 5 sector erase, 6 chip erase, 7 reserved. `req_ready` is the inverse of `busy_i`. A request is taken only in a cycle where valid and ready are both high. Its `resp_valid` pulse and any register update appear one cycle later.
- R3: Set-enable and clear-enable are always granted and set or clear the latch, regardless of pe, bp or the lock pin.
- R4: Protected addresses are decided by bp with a 17-bit address: 00 protects none, 01 protects 18000h–1FFFFh, 10 protects 10000h–1FFFFh, and 11 protects the whole array.
- R5: A data write, page erase or sector erase is granted only when the latch is 1 and the address is not protected.
- R6: A chip erase is granted only when the latch is 1 and bp is 00.
- R7: A status write is granted only when the latch is 1 and the lock pin is not low while pe is 1. When pe is 0, the pin is ignored. A granted write loads pe from data bit 7 and bp from data bits 3:2; the other data bits are ignored.
- R8: Each granted status write, data write, page erase, sector erase or chip erase clears the latch.
- R9: A denied request leaves the latch and the nonvolatile bits unchanged.
- R10: Once a status write has been granted, later changes on the lock pin do not alter its result.
- R11: The reserved kind is always denied and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request (array not busy) |
| req_kind | input | 3 | Request kind code |
| req_addr | input | ADDR_W | Target array address |
| req_data | input | 8 | Byte for a status write |
| busy_i | input | 1 | Array internal cycle in progress |
| hw_lock_n | input | 1 | Active-low status lock pin |
| resp_valid | output | 1 | One-cycle pulse carrying the decision |
| resp_grant | output | 1 | 1 = request allowed, 0 = denied |
| status_o | output | 8 | Status byte for reads |
| nv_o | output | 3 | Nonvolatile bits {pe, bp} |

## Verification
A request is accepted at one rising edge. Its decision, the new latch value and the new nonvolatile bits are all due at the next rising edge. Only the busy bit of the status byte and `req_ready` follow `busy_i` combinationally. The bench drives each request on a falling edge and clears `req_valid` on the following falling edge, after the single accepting edge. At that same falling edge it compares `resp_valid`, `resp_grant` and the status byte. The busy test samples `req_ready` and the status byte in the cycle where `busy_i` is raised, and confirms that no response appears while the stalled request is held.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [2:0] {
    K_SET_WEL   = 3'd0,
    K_CLR_WEL   = 3'd1,
    K_WR_STAT   = 3'd2,
    K_WR_DATA   = 3'd3,
    K_ERASE_PG  = 3'd4,
    K_ERASE_SEC = 3'd5,
    K_ERASE_ALL = 3'd6,
    K_RSVD      = 3'd7
  } req_kind_e;

  typedef struct packed {
    logic       pe;
    logic [1:0] bp;
  } nv_bits_t;
endpackage

// File: rtl/wpg_region_decode.sv
module wpg_region_decode #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;
  logic unused_low;
  assign unused_low = ^addr[TOP-2:0];

  always_comb begin
    unique case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = &addr[TOP -: 2];
      2'b10:   hit = addr[TOP];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpg_policy.sv
module wpg_policy
  import wpg_pkg::*;
(
  input  req_kind_e kind,
  input  logic      wel,
  input  nv_bits_t  nv,
  input  logic      lock_n,
  input  logic      region_hit,
  output logic      grant
);
  logic stat_locked;
  assign stat_locked = nv.pe & ~lock_n;

  always_comb begin
    unique case (kind)
      K_SET_WEL, K_CLR_WEL:                grant = 1'b1;
      K_WR_STAT:                           grant = wel & ~stat_locked;
      K_WR_DATA, K_ERASE_PG, K_ERASE_SEC:  grant = wel & ~region_hit;
      K_ERASE_ALL:                         grant = wel & (nv.bp == 2'b00);
      default:                             grant = 1'b0;
    endcase
  end
endmodule

// File: rtl/wpg_status_regs.sv
module wpg_status_regs
  import wpg_pkg::*;
#(
  parameter logic       RST_PE = 1'b0,
  parameter logic [1:0] RST_BP = 2'b00
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      grant,
  input  req_kind_e kind,
  input  logic      new_pe,
  input  logic [1:0] new_bp,
  output logic      wel,
  output nv_bits_t  nv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      nv.pe <= RST_PE;
      nv.bp <= RST_BP;
    end else if (take && grant) begin
      unique case (kind)
        K_SET_WEL: wel <= 1'b1;
        K_CLR_WEL: wel <= 1'b0;
        K_WR_STAT: begin
          wel   <= 1'b0;
          nv.pe <= new_pe;
          nv.bp <= new_bp;
        end
        default:   wel <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wpg_status_guard.sv
module wpg_status_guard
  import wpg_pkg::*;
#(
  parameter int         ADDR_W = 17,
  parameter logic       RST_PE = 1'b0,
  parameter logic [1:0] RST_BP = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              busy_i,
  input  logic              hw_lock_n,
  output logic              resp_valid,
  output logic              resp_grant,
  output logic [7:0]        status_o,
  output logic [2:0]        nv_o
);
  req_kind_e kind;
  logic      take, region_hit, grant, wel;
  nv_bits_t  nv;
  logic      unused_data;

  assign kind        = req_kind_e'(req_kind);
  assign req_ready   = ~busy_i;
  assign take        = req_valid & req_ready;
  assign unused_data = ^{req_data[6:4], req_data[1:0]};

  wpg_region_decode #(.ADDR_W(ADDR_W)) u_region (
    .bp(nv.bp), .addr(req_addr), .hit(region_hit)
  );

  wpg_policy u_policy (
    .kind(kind), .wel(wel), .nv(nv), .lock_n(hw_lock_n),
    .region_hit(region_hit), .grant(grant)
  );

  wpg_status_regs #(.RST_PE(RST_PE), .RST_BP(RST_BP)) u_regs (
    .clk(clk), .rst_n(rst_n), .take(take), .grant(grant), .kind(kind),
    .new_pe(req_data[7]), .new_bp(req_data[3:2]), .wel(wel), .nv(nv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
    end else begin
      resp_valid <= take;
      resp_grant <= take & grant;
    end
  end

  assign status_o = {nv.pe, 3'b000, nv.bp, wel, busy_i};
  assign nv_o     = nv;
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_kind,
  input logic       hw_lock_n,
  input logic       resp_valid,
  input logic       resp_grant,
  input logic [7:0] status_o,
  input logic [2:0] nv_o
);
  // R2: a response only follows an accepted request taken while not busy
  assert_resp_follows_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid) && $past(req_ready) && !$past(status_o[0])));

  // R6: a granted chip erase needs bp == 00 and the latch set
  assert_chip_erase_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_grant && $past(req_kind) == 3'd6) |-> ($past(nv_o[1:0]) == 2'b00 && $past(status_o[1])));

  // R7: a status write while pe is set and the pin is low is denied
  assert_locked_status_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready && req_kind == 3'd2 && nv_o[2] && !hw_lock_n)) |-> !resp_grant);

  // R8: granted write-type requests leave the latch clear
  assert_latch_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_grant && $past(req_kind) >= 3'd2 && $past(req_kind) <= 3'd6) |-> !status_o[1]);

  // R9: a denial keeps the latch value
  assert_deny_keeps_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_grant) |-> (status_o[1] == $past(status_o[1])));

  // R9: nonvolatile bits only move on a grant
  assert_nv_moves_on_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv_o) |-> resp_grant);

  // R11: the reserved kind is never granted
  assert_reserved_denied_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_kind) == 3'd7) |-> !resp_grant);
endmodule

bind wpg_status_guard wpg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .hw_lock_n(hw_lock_n), .resp_valid(resp_valid),
  .resp_grant(resp_grant), .status_o(status_o), .nv_o(nv_o)
);

// File: tb/wpg_status_guard_test.sv
`timescale 1ns/1ps
module wpg_status_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        busy_i = 1'b0;
  logic        hw_lock_n = 1'b1;
  logic        resp_valid, resp_grant;
  logic [7:0]  status_o;
  logic [2:0]  nv_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wpg_status_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .busy_i(busy_i), .hw_lock_n(hw_lock_n), .resp_valid(resp_valid),
    .resp_grant(resp_grant), .status_o(status_o), .nv_o(nv_o)
  );

  // {kind[3], addr[17], data[8], lock_n, exp_grant, exp_status[8]}
  localparam int NV = 28;
  localparam logic [37:0] VEC [NV] = '{
    {3'd3, 17'h00100, 8'h00, 1'b1, 1'b0, 8'h00}, // R5 latch clear
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h02}, // R3
    {3'd3, 17'h1FFFF, 8'h00, 1'b1, 1'b1, 8'h00}, // R4 bp00 none, R8
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h02},
    {3'd2, 17'h00000, 8'h04, 1'b1, 1'b1, 8'h04}, // R7 bp=01
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h06},
    {3'd3, 17'h18000, 8'h00, 1'b1, 1'b0, 8'h06}, // R4 upper quarter, R9
    {3'd4, 17'h17FFF, 8'h00, 1'b1, 1'b1, 8'h04}, // R4 just below
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h06},
    {3'd6, 17'h00000, 8'h00, 1'b1, 1'b0, 8'h06}, // R6 bp!=00
    {3'd5, 17'h1C000, 8'h00, 1'b1, 1'b0, 8'h06}, // R5 sector protected
    {3'd2, 17'h00000, 8'h88, 1'b0, 1'b1, 8'h88}, // R7 pe=0 pin ignored
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h8A},
    {3'd2, 17'h00000, 8'h00, 1'b0, 1'b0, 8'h8A}, // R7 locked
    {3'd3, 17'h10000, 8'h00, 1'b1, 1'b0, 8'h8A}, // R4 upper half
    {3'd5, 17'h0FFFF, 8'h00, 1'b1, 1'b1, 8'h88}, // R5 below half
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h8A},
    {3'd2, 17'h00000, 8'h70, 1'b1, 1'b1, 8'h00}, // R7 pin high, bits 6:4 ignored
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h02},
    {3'd1, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h00}, // R3 clear
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h02},
    {3'd6, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h00}, // R6 granted, R8
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h02},
    {3'd2, 17'h00000, 8'h0C, 1'b0, 1'b1, 8'h0C}, // R7 bp=11
    {3'd0, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h0E},
    {3'd3, 17'h00000, 8'h00, 1'b1, 1'b0, 8'h0E}, // R4 whole array
    {3'd1, 17'h00000, 8'h00, 1'b1, 1'b1, 8'h0C},
    {3'd7, 17'h00000, 8'h00, 1'b1, 1'b0, 8'h0C}  // R11
  };

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0, 3'd1:       return "R3";
      3'd2:             return "R7";
      3'd3, 3'd4, 3'd5: return "R5 R4";
      3'd6:             return "R6";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] k, input logic [16:0] a,
                        input logic [7:0] d, input logic l);
    @(negedge clk);
    req_kind = k; req_addr = a; req_data = d; hw_lock_n = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset status", status_o, 8'h00);
    check("R1", "reset nv", {5'd0, nv_o}, 8'h00);
    check("R2", "reset resp_valid", {7'd0, resp_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      do_req(v[37:35], v[34:18], v[17:10], v[9]);
      check("R2", "resp_valid", {7'd0, resp_valid}, 8'h01);
      check(tag_of(v[37:35]), "grant", {7'd0, resp_grant}, {7'd0, v[8]});
      check("R1 R8 R9", "status", status_o, v[7:0]);
    end

    // R2 / R1: busy stalls the request and shows in bit 0
    @(negedge clk);
    busy_i = 1'b1; req_kind = 3'd0; req_valid = 1'b1;
    #1;
    check("R1", "busy bit", status_o, 8'h0D);
    check("R2", "ready low while busy", {7'd0, req_ready}, 8'h00);
    @(negedge clk);
    check("R2", "no response while busy", {7'd0, resp_valid}, 8'h00);
    check("R2", "status held while busy", status_o, 8'h0D);
    busy_i = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "accepted after busy", {7'd0, resp_grant}, 8'h01);
    check("R3", "latch set after stall", status_o, 8'h0E);

    // R10: pin drops right after a granted status write
    do_req(3'd2, 17'h0, 8'h80, 1'b1);
    check("R10", "status write granted", {7'd0, resp_grant}, 8'h01);
    hw_lock_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10", "status after pin drop", status_o, 8'h80);
    check("R10", "nv after pin drop", {5'd0, nv_o}, 8'h04);
    check("R2", "response is one pulse", {7'd0, resp_valid}, 8'h00);

    // R1: reset mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "status after reset", status_o, 8'h00);
    check("R1", "resp after reset", {7'd0, resp_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule